// File: doc/BRIEF.md
# Branch Target Buffer with Hot-Block Tracking

This block is a small direct-mapped branch target buffer that also gathers the information a fetch unit needs to find frequently executed basic blocks. Each entry holds a tag and a branch target. It also holds a direction bit, a saturating count of taken outcomes, a hot flag and a previous-phase hot flag. A branch that is resolved not-taken keeps its entry, so the entry does not lose its frequency history.

A lookup port returns the entry state for a fetch PC in the same cycle. A resolve port delivers each branch outcome with its PC, direction and target, and this updates or allocates an entry at the next clock edge. Two sideband strobes act on all entries together. The phase-reset strobe moves each hot flag into the previous-hot flag, then clears the hot flags and zeroes the counters. The clear-previous strobe clears every previous-hot flag, and it is raised when the fetch controller settles into its monitoring stage.

Top module: `btb_hotblock_tracker`

## Requirements
- R1: After reset every entry is empty, so a lookup at any PC reports a miss with all flags 0 and a target of 0.
- R2: A resolve that misses allocates the indexed entry. It stores the tag and the target, sets the valid bit to the taken flag, and sets the counter to zero with both flags clear. The allocating resolve itself is not counted.
- R3: A resolve that hits with taken=0 keeps the entry resident with valid=0 and leaves its counter and target unchanged. A resolve that hits with taken=1 sets valid=1 and stores the new target.
- R4: Each taken resolve that hits adds one to the 4-bit counter. The counter stops at 15 and does not wrap. The at-threshold output is 1 exactly when the counter of the entry that hits equals 15.
- R5: The hot flag of an entry is set on the resolve that brings its counter to 15. It stays set until a phase reset, a reset or a reallocation.
- R6: A phase reset copies every entry's hot flag into its previous-hot flag. In the same edge it clears every hot flag and every counter. Tags, targets and valid bits are kept, and a phase reset takes precedence over a resolve counted in the same cycle.
- R7: The clear-previous strobe clears every previous-hot flag. When it coincides with a phase reset, the previous-hot flags end at 0.
- R8: The entry is chosen by PC bits [5:2] and the tag is PC bits [31:6]. PC bits [1:0] are ignored. A lookup whose tag differs from the stored one misses, and a resolve whose tag differs replaces the entry with zeroed state.
- R9: Lookup outputs follow the lookup PC combinationally. A resolve to the looked-up entry becomes visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Indexed entry is occupied and its tag matches |
| lk_valid | output | 1 | Stored direction bit (1 = taken) |
| lk_hot | output | 1 | Hot flag of the entry |
| lk_prev_hot | output | 1 | Previous-phase hot flag of the entry |
| lk_at_thresh | output | 1 | Entry counter is at its maximum value |
| lk_target | output | PC_W | Stored branch target (0 on miss) |
| rs_en | input | 1 | Resolve update strobe |
| rs_pc | input | PC_W | PC of the resolved branch |
| rs_taken | input | 1 | Resolved direction |
| rs_target | input | PC_W | Resolved target |
| phase_reset | input | 1 | Move hot flags into previous-hot, then clear hot flags and counters |
| clear_prev | input | 1 | Clear all previous-hot flags |

## Verification
The bench builds the block with its defaults: 16 entries, a 32-bit PC and a 4-bit counter. With these values every entry can be swept after each phase of stimulus. Each entry is driven to a different count, so every counter value from 0 to 15 and the saturation at the top are observed in one pass. The small counter also lets the bench push an entry to hot quickly, repeat this across several phase resets and check both strobes together.

// File: rtl/hbt_pkg.sv
package hbt_pkg;

    typedef struct packed {
        logic hit;
        logic valid;
        logic hot;
        logic prev_hot;
        logic at_thresh;
    } hbt_flags_t;

    localparam hbt_flags_t HBT_MISS = '{hit: 1'b0, valid: 1'b0, hot: 1'b0,
                                        prev_hot: 1'b0, at_thresh: 1'b0};

endpackage

// File: rtl/hbt_entry.sv
module hbt_entry #(
    parameter int TAG_W = 26,
    parameter int TGT_W = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic             phase_reset,
    input  logic             clear_prev,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             match,
    output logic             valid,
    output logic             hot,
    output logic             prev_hot,
    output logic             full,
    output logic [TGT_W-1:0] tgt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             occ;
    logic [TAG_W-1:0] tag;
    logic [CNT_W-1:0] cnt;
    logic             alloc, upd;
    logic [CNT_W-1:0] cnt_inc;

    assign alloc   = wr_sel && !(occ && tag == wr_tag);
    assign upd     = wr_sel && occ && tag == wr_tag;
    assign cnt_inc = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ      <= 1'b0;
            tag      <= '0;
            tgt      <= '0;
            valid    <= 1'b0;
            cnt      <= '0;
            hot      <= 1'b0;
            prev_hot <= 1'b0;
        end else begin
            if (alloc) begin
                occ   <= 1'b1;
                tag   <= wr_tag;
                tgt   <= wr_tgt;
                valid <= wr_taken;
                cnt   <= '0;
                hot   <= 1'b0;
            end else if (upd) begin
                valid <= wr_taken;
                if (wr_taken) begin
                    tgt <= wr_tgt;
                    cnt <= cnt_inc;
                    hot <= hot | (cnt_inc == CNT_MAX);
                end
            end
            if (phase_reset) begin
                cnt <= '0;
                hot <= 1'b0;
            end
            if (alloc || clear_prev)
                prev_hot <= 1'b0;
            else if (phase_reset)
                prev_hot <= hot;
        end
    end

    assign match = occ && (tag == lk_tag);
    assign full  = (cnt == CNT_MAX);

endmodule

// File: rtl/hbt_lookup.sv
module hbt_lookup
    import hbt_pkg::*;
#(
    parameter int N     = 16,
    parameter int TGT_W = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             match    [N],
    input  logic             valid    [N],
    input  logic             hot      [N],
    input  logic             prev_hot [N],
    input  logic             full     [N],
    input  logic [TGT_W-1:0] tgt      [N],
    output hbt_flags_t       flags,
    output logic [TGT_W-1:0] target
);
    always_comb begin
        flags  = HBT_MISS;
        target = '0;
        if (match[idx]) begin
            flags.hit       = 1'b1;
            flags.valid     = valid[idx];
            flags.hot       = hot[idx];
            flags.prev_hot  = prev_hot[idx];
            flags.at_thresh = full[idx];
            target          = tgt[idx];
        end
    end
endmodule

// File: rtl/btb_hotblock_tracker.sv
module btb_hotblock_tracker
    import hbt_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int PC_W      = 32,
    parameter int CNT_W     = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic            lk_valid,
    output logic            lk_hot,
    output logic            lk_prev_hot,
    output logic            lk_at_thresh,
    output logic [PC_W-1:0] lk_target,
    input  logic            rs_en,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic            phase_reset,
    input  logic            clear_prev
);
    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam int IDX_LO = 2;
    localparam int TAG_LO = IDX_LO + IDX_W;
    localparam int TAG_W = PC_W - TAG_LO;

    logic [IDX_W-1:0] lk_idx, rs_idx;
    logic [TAG_W-1:0] lk_tag, rs_tag;
    logic             unused_lo;

    assign lk_idx    = lk_pc[TAG_LO-1:IDX_LO];
    assign rs_idx    = rs_pc[TAG_LO-1:IDX_LO];
    assign lk_tag    = lk_pc[PC_W-1:TAG_LO];
    assign rs_tag    = rs_pc[PC_W-1:TAG_LO];
    assign unused_lo = ^{lk_pc[IDX_LO-1:0], rs_pc[IDX_LO-1:0]};

    logic            e_match [N_ENTRIES];
    logic            e_valid [N_ENTRIES];
    logic            e_hot   [N_ENTRIES];
    logic            e_prev  [N_ENTRIES];
    logic            e_full  [N_ENTRIES];
    logic [PC_W-1:0] e_tgt   [N_ENTRIES];

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        hbt_entry #(.TAG_W(TAG_W), .TGT_W(PC_W), .CNT_W(CNT_W)) u_ent (
            .clk        (clk),
            .rst        (rst),
            .wr_sel     (rs_en && rs_idx == IDX_W'(g)),
            .wr_tag     (rs_tag),
            .wr_taken   (rs_taken),
            .wr_tgt     (rs_target),
            .phase_reset(phase_reset),
            .clear_prev (clear_prev),
            .lk_tag     (lk_tag),
            .match      (e_match[g]),
            .valid      (e_valid[g]),
            .hot        (e_hot[g]),
            .prev_hot   (e_prev[g]),
            .full       (e_full[g]),
            .tgt        (e_tgt[g])
        );
    end

    hbt_flags_t flags;

    hbt_lookup #(.N(N_ENTRIES), .TGT_W(PC_W)) u_lk (
        .idx     (lk_idx),
        .match   (e_match),
        .valid   (e_valid),
        .hot     (e_hot),
        .prev_hot(e_prev),
        .full    (e_full),
        .tgt     (e_tgt),
        .flags   (flags),
        .target  (lk_target)
    );

    assign lk_hit       = flags.hit;
    assign lk_valid     = flags.valid;
    assign lk_hot       = flags.hot;
    assign lk_prev_hot  = flags.prev_hot;
    assign lk_at_thresh = flags.at_thresh;

endmodule

// File: rtl/hbt_checker.sv
module hbt_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] lk_pc,
    input logic            lk_hit,
    input logic            lk_valid,
    input logic            lk_hot,
    input logic            lk_prev_hot,
    input logic            lk_at_thresh,
    input logic            rs_en,
    input logic [PC_W-1:0] rs_pc,
    input logic            rs_taken,
    input logic            phase_reset,
    input logic            clear_prev
);
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> !lk_hit);

    assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> !(lk_valid || lk_hot || lk_prev_hot || lk_at_thresh));

    assert_nt_resident_R3: assert property (@(posedge clk) disable iff (rst)
        (rs_en && !rs_taken && rs_pc == lk_pc && !phase_reset)
        |=> (lk_pc != $past(lk_pc)) || (lk_hit && !lk_valid));

    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (rs_en && rs_taken && rs_pc == lk_pc && lk_hit && lk_at_thresh && !phase_reset)
        |=> (lk_pc != $past(lk_pc)) || lk_at_thresh);

    assert_thresh_hot_R5: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_at_thresh) |-> lk_hot);

    assert_phase_clear_R6: assert property (@(posedge clk) disable iff (rst)
        phase_reset |=> !lk_hot && !lk_at_thresh);

    assert_prev_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear_prev |=> !lk_prev_hot);

endmodule

bind btb_hotblock_tracker hbt_checker #(.PC_W(PC_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_pc       (lk_pc),
    .lk_hit      (lk_hit),
    .lk_valid    (lk_valid),
    .lk_hot      (lk_hot),
    .lk_prev_hot (lk_prev_hot),
    .lk_at_thresh(lk_at_thresh),
    .rs_en       (rs_en),
    .rs_pc       (rs_pc),
    .rs_taken    (rs_taken),
    .phase_reset (phase_reset),
    .clear_prev  (clear_prev)
);

// File: tb/sim_btb_hotblock_tracker.sv
`timescale 1ns/1ps
module sim_btb_hotblock_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_valid, lk_hot, lk_prev_hot, lk_at_thresh;
    logic [31:0] lk_target;
    logic        rs_en = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic        phase_reset = 1'b0;
    logic        clear_prev = 1'b0;

    always #2.5 clk = ~clk;

    btb_hotblock_tracker u0 (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_valid(lk_valid),
        .lk_hot(lk_hot), .lk_prev_hot(lk_prev_hot), .lk_at_thresh(lk_at_thresh),
        .lk_target(lk_target), .rs_en(rs_en), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_target(rs_target), .phase_reset(phase_reset), .clear_prev(clear_prev)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model state
    bit          m_occ [16];
    logic [25:0] m_tag [16];
    logic [31:0] m_tgt [16];
    bit          m_val [16];
    int          m_cnt [16];
    bit          m_hot [16];
    bit          m_prev[16];

    function automatic logic [31:0] mk_pc(input logic [25:0] tg, input int ix);
        return {tg, 4'(ix), 2'b00};
    endfunction

    function automatic logic [31:0] mk_tgt(input logic [31:0] pc, input int salt);
        return (pc ^ 32'h5A5A_0000) + 32'(salt * 4);
    endfunction

    task automatic model_step(input bit en, input logic [31:0] pc, input bit tk,
                              input logic [31:0] tgt, input bit pr, input bit cp);
        for (int i = 0; i < 16; i++) begin
            bit sel, al, up, old_hot;
            sel = en && (pc[5:2] == 4'(i));
            al = sel && !(m_occ[i] && m_tag[i] == pc[31:6]);
            up = sel && !al;
            old_hot = m_hot[i];
            if (al) begin
                m_occ[i] = 1; m_tag[i] = pc[31:6]; m_tgt[i] = tgt;
                m_val[i] = tk; m_cnt[i] = 0; m_hot[i] = 0;
            end else if (up) begin
                m_val[i] = tk;
                if (tk) begin
                    m_tgt[i] = tgt;
                    if (m_cnt[i] < 15) m_cnt[i]++;
                    if (m_cnt[i] == 15) m_hot[i] = 1;
                end
            end
            if (pr) begin m_cnt[i] = 0; m_hot[i] = 0; end
            if (al || cp) m_prev[i] = 0;
            else if (pr) m_prev[i] = old_hot;
        end
    endtask

    // called at a negedge; one clock edge is consumed
    task automatic step(input bit en, input logic [31:0] pc, input bit tk,
                        input logic [31:0] tgt, input bit pr, input bit cp);
        rs_en = en; rs_pc = pc; rs_taken = tk; rs_target = tgt;
        phase_reset = pr; clear_prev = cp;
        @(posedge clk);
        model_step(en, pc, tk, tgt, pr, cp);
        @(negedge clk);
        rs_en = 0; phase_reset = 0; clear_prev = 0;
    endtask

    task automatic check_pc(input logic [31:0] pc, input string req);
        int i;
        bit eh;
        logic [4:0] ef, af;
        logic [31:0] et;
        lk_pc = pc;
        #1;
        i  = int'(pc[5:2]);
        eh = m_occ[i] && m_tag[i] == pc[31:6];
        ef = eh ? {1'b1, m_val[i], m_hot[i], m_prev[i], m_cnt[i] == 15} : 5'b0;
        et = eh ? m_tgt[i] : 32'h0;
        af = {lk_hit, lk_valid, lk_hot, lk_prev_hot, lk_at_thresh};
        n_tests++;
        if (af !== ef || lk_target !== et) begin
            n_fail++;
            $display("FAIL %s pc=%h flags(hit,val,hot,prev,thr) act=%b exp=%b tgt act=%h exp=%h",
                     req, pc, af, ef, lk_target, et);
        end
    endtask

    task automatic check_all(input logic [25:0] tg, input string req);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check_pc(mk_pc(tg, i), req);
        end
    endtask

    localparam logic [25:0] TA = 26'h12_3456;
    localparam logic [25:0] TB = 26'h2A_0F0F;

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_occ[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; m_val[i] = 0;
            m_cnt[i] = 0; m_hot[i] = 0; m_prev[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        check_all(TA, "R1");

        // R2: allocate every index, direction alternating
        for (int i = 0; i < 16; i++)
            step(1, mk_pc(TA, i), i[0], mk_tgt(mk_pc(TA, i), 0), 0, 0);
        check_all(TA, "R2");

        // R4/R5: entry i receives i taken resolves; entry 15 gets 3 extra (saturation)
        for (int i = 0; i < 16; i++)
            for (int k = 0; k < i + (i == 15 ? 3 : 0); k++)
                step(1, mk_pc(TA, i), 1, mk_tgt(mk_pc(TA, i), k + 1), 0, 0);
        check_all(TA, "R4 R5");

        // R3: not-taken on odd entries keeps them resident
        for (int i = 1; i < 16; i += 2)
            step(1, mk_pc(TA, i), 0, 32'hDEAD_0000, 0, 0);
        check_all(TA, "R3");

        // R8: low PC bits ignored
        @(negedge clk);
        check_pc(mk_pc(TA, 6) | 32'h3, "R8 low bits");

        // R9: same-cycle resolve only visible after the edge
        @(negedge clk);
        lk_pc = mk_pc(TA, 14);
        rs_en = 1; rs_pc = mk_pc(TA, 14); rs_taken = 1; rs_target = 32'h0000_BEE0;
        check_pc(mk_pc(TA, 14), "R9 before edge");
        @(posedge clk);
        model_step(1, mk_pc(TA, 14), 1, 32'h0000_BEE0, 0, 0);
        @(negedge clk);
        rs_en = 0;
        check_pc(mk_pc(TA, 14), "R9 after edge");

        // R6: phase reset with a resolve in the same cycle
        step(1, mk_pc(TA, 9), 1, 32'h0000_1230, 1, 0);
        check_all(TA, "R6");

        // R6/R7: drive entry 2 hot, then phase reset with clear-previous
        for (int k = 0; k < 15; k++)
            step(1, mk_pc(TA, 2), 1, mk_tgt(mk_pc(TA, 2), k), 0, 0);
        check_all(TA, "R5 rehot");
        step(0, '0, 0, '0, 1, 1);
        check_all(TA, "R7 combined");

        // R6/R7: entry 5 hot, phase reset, then clear-previous alone
        for (int k = 0; k < 15; k++)
            step(1, mk_pc(TA, 5), 1, mk_tgt(mk_pc(TA, 5), k), 0, 0);
        step(0, '0, 0, '0, 1, 0);
        check_all(TA, "R6 copy");
        step(0, '0, 0, '0, 0, 1);
        check_all(TA, "R7");

        // R8: tag mismatch misses, then replaces with zeroed state
        for (int k = 0; k < 15; k++)
            step(1, mk_pc(TA, 7), 1, mk_tgt(mk_pc(TA, 7), k), 0, 0);
        step(0, '0, 0, '0, 1, 0);
        @(negedge clk);
        check_pc(mk_pc(TB, 7), "R8 mismatch");
        step(1, mk_pc(TB, 7), 1, 32'h0000_7770, 0, 0);
        check_pc(mk_pc(TB, 7), "R8 realloc");
        check_pc(mk_pc(TA, 7), "R8 old tag");
        check_all(TA, "R8 others");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule